// File: doc/BRIEF.md
# Effective Address and Next-PC Unit

This unit forms the memory address and the next program-counter value for a 16-bit word-addressed processor. Its inputs are the instruction word, the program counter after the fetch increment, a base-register value that has already been read from the register file, and a value from the shared bus. An adder sums two operands. The first operand is the incremented PC or the base register. The second operand is zero or one of three sign-extended offset fields cut from the low bits of the instruction. The adder supports PC-relative loads, stores and branches, base-plus-offset access, register jumps and the longer PC-relative subroutine call.

Two selectors choose the outputs. The memory-address selector picks the adder sum or a trap-table address. That address is the low instruction byte, zero-extended, and it does not pass through the adder. The next-PC selector picks the incremented PC, the adder sum, or the bus value (for example a word read from the trap table). Both results are registered once, so each one appears on the clock edge after its inputs are sampled. A synchronous active-high reset clears both results.

Top module: `ea_unit`

## Requirements
- R1: While `rst` is high at a rising edge, both `mar_addr` and `next_pc` are 0x0000 after that edge.
- R2: With `opnd2_sel` = 1, the second adder operand is instruction bits [5:0] sign-extended, which covers -32 to +31.
- R3: With `opnd2_sel` = 2, the second adder operand is instruction bits [8:0] sign-extended, which covers -256 to +255.
- R4: With `opnd2_sel` = 3, the second adder operand is instruction bits [10:0] sign-extended, which covers -1024 to +1023.
- R5: With `opnd2_sel` = 0, the second adder operand is zero, so the sum equals the first operand.
- R6: With `opnd1_sel` = 0, the first adder operand is `pc_inc`. With `opnd1_sel` = 1, it is `base_val`.
- R7: The sum wraps modulo 2^16. For example, 0xFFFF + 1 gives 0x0000 and 0x0000 - 1 gives 0xFFFF.
- R8: With `mar_sel` = 0, `mar_addr` is the adder sum. With `mar_sel` = 1, `mar_addr` is {8'h00, instr[7:0]} and the adder operands have no effect on it.
- R9: `pc_sel` selects `next_pc` as follows: 0 gives `pc_inc`, 1 gives the adder sum, 2 gives `bus_val`, and 3 is reserved and gives `pc_inc`.
- R10: Both outputs are registered. Inputs sampled at one rising edge appear on the outputs after that same edge and stay there until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | Program counter after the fetch increment |
| base_val | input | 16 | Base register contents |
| bus_val | input | 16 | Value from the shared bus |
| opnd1_sel | input | 1 | First adder operand: 0 PC, 1 base register |
| opnd2_sel | input | 2 | Second adder operand: 0 zero, 1 six-bit, 2 nine-bit, 3 eleven-bit offset |
| mar_sel | input | 1 | Memory address: 0 adder sum, 1 trap vector |
| pc_sel | input | 2 | Next PC: 0 incremented, 1 adder sum, 2 bus, 3 incremented |
| mar_addr | output | 16 | Registered memory address |
| next_pc | output | 16 | Registered next program counter |

## Verification
Directed patterns place every offset field at its most negative and most positive value. This shows whether the sign bit is taken from the right position and whether neighbouring instruction bits leak into the offset. Further patterns pair PC and base operands with sums that cross 0xFFFF and 0x0000, which exposes a carry that is dropped or kept. Trap-vector cycles set the upper instruction byte and load the adder inputs with non-zero values, so any path from the adder into the trap address shows up. Seeded random cycles then sweep all select combinations against a behavioural integer model. That model is compared on every clock, and it catches a wrong mux leg or a missing register stage.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [0:0] {
    OP1_PC   = 1'b0,
    OP1_BASE = 1'b1
  } op1_e;

  typedef enum logic [1:0] {
    OP2_ZERO  = 2'd0,
    OP2_SHORT = 2'd1,
    OP2_MID   = 2'd2,
    OP2_LONG  = 2'd3
  } op2_e;

  typedef enum logic [0:0] {
    MAR_SUM  = 1'b0,
    MAR_TRAP = 1'b1
  } mar_e;

  typedef enum logic [1:0] {
    NPC_INC  = 2'd0,
    NPC_SUM  = 2'd1,
    NPC_BUS  = 2'd2,
    NPC_RSVD = 2'd3
  } npc_e;
endpackage

// File: rtl/ea_offset_sel.sv
module ea_offset_sel #(
  parameter int DW      = 16,
  parameter int SHORT_W = 6,
  parameter int MID_W   = 9,
  parameter int LONG_W  = 11
) (
  input  logic [LONG_W-1:0] field,
  input  logic [1:0]        sel,
  output logic [DW-1:0]     offset
);
  localparam int NUM_EXT = 3;

  logic [DW-1:0] ext [NUM_EXT];

  // one sign extender per offset width
  for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
    localparam int FW = (g == 0) ? SHORT_W : (g == 1) ? MID_W : LONG_W;
    assign ext[g] = {{(DW-FW){field[FW-1]}}, field[FW-1:0]};
  end

  always_comb begin
    unique case (sel)
      2'd1:    offset = ext[0];
      2'd2:    offset = ext[1];
      2'd3:    offset = ext[2];
      default: offset = '0;
    endcase
  end
endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
  parameter int DW = 16
) (
  input  logic          opnd1_sel,
  input  logic [DW-1:0] pc_inc,
  input  logic [DW-1:0] base_val,
  input  logic [DW-1:0] offset,
  output logic [DW-1:0] sum
);
  logic [DW-1:0] opnd1;

  assign opnd1 = opnd1_sel ? base_val : pc_inc;
  // carry out is dropped: addresses wrap
  assign sum   = opnd1 + offset;
endmodule

// File: rtl/ea_out_reg.sv
module ea_out_reg #(
  parameter int DW     = 16,
  parameter int TRAP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        pc_sel,
  input  logic              mar_sel,
  input  logic [DW-1:0]     sum,
  input  logic [TRAP_W-1:0] trap_vec,
  input  logic [DW-1:0]     pc_inc,
  input  logic [DW-1:0]     bus_val,
  output logic [DW-1:0]     mar_addr,
  output logic [DW-1:0]     next_pc
);
  import ea_pkg::*;

  logic [DW-1:0] mar_d;
  logic [DW-1:0] npc_d;

  always_comb begin
    mar_d = (mar_e'(mar_sel) == MAR_TRAP) ? {{(DW-TRAP_W){1'b0}}, trap_vec} : sum;
    unique case (npc_e'(pc_sel))
      NPC_SUM: npc_d = sum;
      NPC_BUS: npc_d = bus_val;
      default: npc_d = pc_inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_addr <= '0;
      next_pc  <= '0;
    end else begin
      mar_addr <= mar_d;
      next_pc  <= npc_d;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (mar_addr == '0 && next_pc == '0));
  // R8
  trap_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mar_sel == 1'b1) |=> (mar_addr[DW-1:TRAP_W] == '0 && mar_addr[TRAP_W-1:0] == $past(trap_vec)));
  // R9
  npc_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'd2) |=> (next_pc == $past(bus_val)));
  // R9
  npc_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'd0 || pc_sel == 2'd3) |=> (next_pc == $past(pc_inc)));
endmodule

// File: rtl/ea_unit.sv
module ea_unit #(
  parameter int DW      = 16,
  parameter int SHORT_W = 6,
  parameter int MID_W   = 9,
  parameter int LONG_W  = 11,
  parameter int TRAP_W  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] instr,
  input  logic [DW-1:0] pc_inc,
  input  logic [DW-1:0] base_val,
  input  logic [DW-1:0] bus_val,
  input  logic          opnd1_sel,
  input  logic [1:0]    opnd2_sel,
  input  logic          mar_sel,
  input  logic [1:0]    pc_sel,
  output logic [DW-1:0] mar_addr,
  output logic [DW-1:0] next_pc
);
  logic [DW-1:0] offset;
  logic [DW-1:0] sum;
  logic          unused_hi;

  // opcode and register-index bits above the longest offset feed nothing here
  assign unused_hi = ^instr[DW-1:LONG_W];

  ea_offset_sel #(.DW(DW), .SHORT_W(SHORT_W), .MID_W(MID_W), .LONG_W(LONG_W)) u_off (
    .field  (instr[LONG_W-1:0]),
    .sel    (opnd2_sel),
    .offset (offset)
  );

  ea_adder #(.DW(DW)) u_add (
    .opnd1_sel (opnd1_sel),
    .pc_inc    (pc_inc),
    .base_val  (base_val),
    .offset    (offset),
    .sum       (sum)
  );

  ea_out_reg #(.DW(DW), .TRAP_W(TRAP_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .pc_sel   (pc_sel),
    .mar_sel  (mar_sel),
    .sum      (sum),
    .trap_vec (instr[TRAP_W-1:0]),
    .pc_inc   (pc_inc),
    .bus_val  (bus_val),
    .mar_addr (mar_addr),
    .next_pc  (next_pc)
  );

  // R5
  zero_offset_base_chk: assert property (@(posedge clk) disable iff (rst)
    (opnd2_sel == 2'd0 && opnd1_sel && !mar_sel) |=> (mar_addr == $past(base_val)));
  // R10
  npc_sum_match_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'd1 && !mar_sel) |=> (next_pc == mar_addr));
endmodule

// File: tb/tb_ea_unit.sv
module tb_ea_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = '0, pc_inc = '0, base_val = '0, bus_val = '0;
  logic        opnd1_sel = 1'b0, mar_sel = 1'b0;
  logic [1:0]  opnd2_sel = '0, pc_sel = '0;
  logic [15:0] mar_addr, next_pc;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_mar, exp_npc;
  string exp_tag;

  always #5 clk = ~clk;

  ea_unit dut (
    .clk(clk), .rst(rst), .instr(instr), .pc_inc(pc_inc), .base_val(base_val),
    .bus_val(bus_val), .opnd1_sel(opnd1_sel), .opnd2_sel(opnd2_sel),
    .mar_sel(mar_sel), .pc_sel(pc_sel), .mar_addr(mar_addr), .next_pc(next_pc)
  );

  function automatic int sfield(logic [15:0] w, int width);
    int v = int'(w) & ((1 << width) - 1);
    if (v >= (1 << (width - 1))) v = v - (1 << width);
    return v;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, compute the model result, check one edge later
  task automatic apply(logic [15:0] ir, logic [15:0] pc, logic [15:0] bs, logic [15:0] bv,
                       logic o1, logic [1:0] o2, logic ms, logic [1:0] ps);
    int a, off, s;
    logic [15:0] sum16;
    instr = ir; pc_inc = pc; base_val = bs; bus_val = bv;
    opnd1_sel = o1; opnd2_sel = o2; mar_sel = ms; pc_sel = ps;
    a = o1 ? int'(bs) : int'(pc);
    case (o2)
      2'd1: off = sfield(ir, 6);
      2'd2: off = sfield(ir, 9);
      2'd3: off = sfield(ir, 11);
      default: off = 0;
    endcase
    s = (a + off) % 65536;
    if (s < 0) s += 65536;
    sum16 = 16'(s);
    exp_mar = ms ? {8'h00, ir[7:0]} : sum16;
    case (ps)
      2'd1: exp_npc = sum16;
      2'd2: exp_npc = bv;
      default: exp_npc = pc;
    endcase
    case (o2)
      2'd0: exp_tag = "R5/R6/R7";
      2'd1: exp_tag = "R2/R6/R7";
      2'd2: exp_tag = "R3/R6/R7";
      default: exp_tag = "R4/R6/R7";
    endcase
    @(negedge clk);
    check({exp_tag, ms ? " R8 R10 mar" : " R10 mar"}, mar_addr, exp_mar);
    check({"R9 R10 npc ", exp_tag}, next_pc, exp_npc);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    instr = 16'hFFFF; bus_val = 16'h1234; pc_sel = 2'd2;
    repeat (3) @(negedge clk);
    check("R1 reset mar", mar_addr, 16'h0000);
    check("R1 reset npc", next_pc, 16'h0000);
    rst = 1'b0;
    // R2 limits with junk in higher bits
    apply(16'hFFE0, 16'h3000, 16'h4000, 16'h0, 1'b1, 2'd1, 1'b0, 2'd1);
    apply(16'h001F, 16'h3000, 16'h4000, 16'h0, 1'b1, 2'd1, 1'b0, 2'd1);
    // R3 limits
    apply(16'hF100, 16'h3000, 16'h4000, 16'h0, 1'b0, 2'd2, 1'b0, 2'd1);
    apply(16'h00FF, 16'h3000, 16'h4000, 16'h0, 1'b0, 2'd2, 1'b0, 2'd1);
    // R4 limits
    apply(16'hF400, 16'h3000, 16'h4000, 16'h0, 1'b0, 2'd3, 1'b0, 2'd1);
    apply(16'h03FF, 16'h3000, 16'h4000, 16'h0, 1'b0, 2'd3, 1'b0, 2'd1);
    // R5 zero offset, R6 operand choice
    apply(16'h07FF, 16'h3000, 16'h3500, 16'h0, 1'b1, 2'd0, 1'b0, 2'd1);
    apply(16'h07FF, 16'h3000, 16'h3500, 16'h0, 1'b0, 2'd0, 1'b0, 2'd1);
    // R7 wrap both directions
    apply(16'h0001, 16'hFFFF, 16'h0, 16'h0, 1'b0, 2'd1, 1'b0, 2'd1);
    apply(16'h003F, 16'h0000, 16'h0000, 16'h0, 1'b1, 2'd1, 1'b0, 2'd1);
    // R8 trap vector ignores adder
    apply(16'hF025, 16'h8123, 16'h7777, 16'h0, 1'b1, 2'd3, 1'b1, 2'd0);
    apply(16'hF0FF, 16'hFFFF, 16'hFFFF, 16'h0, 1'b0, 2'd2, 1'b1, 2'd0);
    // R9 all next-pc codes
    apply(16'h0010, 16'h2000, 16'h0, 16'hBEEF, 1'b0, 2'd2, 1'b0, 2'd2);
    apply(16'h0010, 16'h2000, 16'h0, 16'hBEEF, 1'b0, 2'd2, 1'b0, 2'd3);
    apply(16'h0010, 16'h2000, 16'h0, 16'hBEEF, 1'b0, 2'd2, 1'b0, 2'd0);
    // R10 random sweep, one result per edge
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom(i + 7);
      apply(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
            r[0], r[2:1], r[3], r[5:4]);
    end
    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset mar", mar_addr, 16'h0000);
    check("R1 mid reset npc", next_pc, 16'h0000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule